// File: doc/BRIEF.md
# Segmented Approximate Adder with Switchable Exact Correction

This block adds two N-bit unsigned operands with a carry chain that is broken into K-bit segments. Each segment above the second one takes its carry-in from a short speculative window: a 2K-bit sub-adder that adds the segment together with the segment just below it, assuming no carry enters that lower segment. The lowest sub-adder covers the bottom two segments and supplies all 2K of its result bits. Each higher sub-adder supplies only its upper K bits, and its lower K bits exist only to produce the speculated carry. No carry therefore travels further than 2K bit positions in the approximate path.

A detector marks every segment whose speculated carry-in is wrong. That happens when the window below receives a carry while its lone K-bit partial sum is all ones. The error output is the OR of these marks. When the exact-mode input is high, a correction stage recomputes the true carry into every segment at segment granularity and adds each missed carry into its segment, which gives the true sum and carry-out. When the input is low, the speculative result is returned. Operands and mode are sampled on a clock edge, and the sum, carry-out and error flag appear registered one cycle later. Synchronous active-high reset clears all outputs.

Top module: `aca_top`

## Requirements
- R1: While `rst` is high at a rising edge, `sum_o`, `cout_o` and `err_o` are all zero at the following cycle.
- R2: With `rst` low, the outputs after a rising edge reflect the `a_i`, `b_i` and `exact_i` values sampled at that edge, with one cycle of latency.
- R3: The low 2K bits of `sum_o` always equal bits [2K-1:0] of `a_i + b_i`, in both modes.
- R4: With `exact_i` = 0, each output segment j ≥ 2 (bits [(j+1)K-1 : jK]) equals (A_j + B_j + c_j) mod 2^K. Here c_j is the carry out of A_{j-1} + B_{j-1} computed alone, with no carry-in.
- R5: With `exact_i` = 0, `cout_o` is the carry out of the top segment's sum A_top + B_top + c_top, with c_top speculated as in R4.
- R6: With `exact_i` = 0, the value {cout_o, sum_o} never exceeds the true (N+1)-bit sum.
- R7: `err_o` is 1 exactly when some segment j ≥ 2 has an all-ones lone partial sum in segment j-1 together with a speculated carry into segment j-1. This holds exactly when the approximate (N+1)-bit result differs from the true sum.
- R8: With `exact_i` = 1, {cout_o, sum_o} equals the true (N+1)-bit sum `a_i + b_i` for every operand pair.
- R9: With `exact_i` = 1, `err_o` still reports whether the approximate result for the same operands would have been wrong.
- R10: The value 1 on `exact_i` selects exact results and the value 0 selects approximate results. The mode can change from one cycle to the next, and each sample takes effect at its own edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | N | First operand |
| b_i | input | N | Second operand |
| exact_i | input | 1 | 1 = exact corrected result, 0 = speculative result |
| sum_o | output | N | Registered sum |
| cout_o | output | 1 | Registered carry-out |
| err_o | output | 1 | Registered flag: speculative result differs from the true sum |

## Verification
The clocked assertions assume that the operands and the mode are known, two-state values at every sampled edge after reset. They also assume that the output sampled one cycle after reset deassertion belongs to the first post-reset input. The stimulus meets both conditions: it changes inputs only on falling edges, keeps reset high from time zero, and drives a defined value on every cycle. A reduced configuration with N = 8 and K = 2 is swept over every operand pair in both modes. That sweep covers all chained-carry patterns, including segment carries that ripple through several all-ones segments.

// File: rtl/aca_pkg.sv
package aca_pkg;

  typedef enum logic {
    ACC_SPECULATE = 1'b0,
    ACC_EXACT     = 1'b1
  } acc_mode_e;

  function automatic int unsigned seg_count(input int unsigned width, input int unsigned seg);
    return width / seg;
  endfunction

endpackage

// File: rtl/aca_window.sv
module aca_window #(
  parameter int K = 4
) (
  input  logic [2*K-1:0] a_win,
  input  logic [2*K-1:0] b_win,
  output logic [K-1:0]   lo_sum,
  output logic           lo_cout,
  output logic           lo_ones,
  output logic [K-1:0]   hi_sum,
  output logic           hi_cout
);
  logic [K:0] lo_full;
  logic [K:0] hi_full;

  always_comb begin
    lo_full = {1'b0, a_win[K-1:0]} + {1'b0, b_win[K-1:0]};
    hi_full = {1'b0, a_win[2*K-1:K]} + {1'b0, b_win[2*K-1:K]} + {{K{1'b0}}, lo_full[K]};
  end

  assign lo_sum  = lo_full[K-1:0];
  assign lo_cout = lo_full[K];
  assign lo_ones = &lo_full[K-1:0];
  assign hi_sum  = hi_full[K-1:0];
  assign hi_cout = hi_full[K];

  always_comb begin
    p_ones_no_carry_r7: assert (!(lo_ones && lo_cout))
      else $error("lone partial sum all ones together with a carry out");
  end
endmodule

// File: rtl/aca_fix.sv
module aca_fix #(
  parameter int N = 16,
  parameter int K = 4
) (
  input  logic [N-1:0]        approx_sum,
  input  logic                approx_cout,
  input  logic [N/K-1:0]      spec_c,
  input  logic [N/K-2:0]      prop,
  input  logic                exact_sel,
  output logic [N-1:0]        sum,
  output logic                cout,
  output logic                err
);
  import aca_pkg::*;
  localparam int SEGS = seg_count(N, K);

  logic [SEGS-1:0] true_c;
  logic [SEGS-1:0] missed;
  logic [SEGS-1:0] mark;
  logic [N-1:0]    fixed_sum;
  logic            fixed_cout;

  assign true_c[0] = 1'b0;
  assign missed[0] = 1'b0;
  assign mark[0]   = 1'b0;
  assign fixed_sum[K-1:0] = approx_sum[K-1:0];

  for (genvar j = 1; j < SEGS; j++) begin : g_seg
    assign true_c[j] = spec_c[j] | (prop[j-1] & true_c[j-1]);
    assign missed[j] = true_c[j] & ~spec_c[j];
    assign mark[j]   = prop[j-1] & spec_c[j-1];
    assign fixed_sum[j*K +: K] = approx_sum[j*K +: K] + K'(missed[j]);
  end

  assign fixed_cout = approx_cout | (missed[SEGS-1] & (&approx_sum[N-1 -: K]));
  assign err = |mark;

  always_comb begin
    if (acc_mode_e'(exact_sel) == ACC_EXACT) begin
      sum  = fixed_sum;
      cout = fixed_cout;
    end else begin
      sum  = approx_sum;
      cout = approx_cout;
    end
  end

  always_comb begin
    p_flag_matches_miss_r7: assert ((|missed) == err)
      else $error("error flag disagrees with missed carries");
    p_clean_unchanged_r9: assert (err || (fixed_sum == approx_sum && fixed_cout == approx_cout))
      else $error("correction altered a clean result");
  end
endmodule

// File: rtl/aca_top.sv
module aca_top #(
  parameter int N = 16,
  parameter int K = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         exact_i,
  output logic [N-1:0] sum_o,
  output logic         cout_o,
  output logic         err_o
);
  import aca_pkg::*;
  localparam int SEGS = seg_count(N, K);

  logic [N-1:0]    approx_sum;
  logic            approx_cout;
  logic [SEGS-1:0] spec_c;
  logic [SEGS-2:0] prop;
  logic [N-1:0]    comb_sum;
  logic            comb_cout;
  logic            comb_err;

  assign spec_c[0] = 1'b0;

  for (genvar j = 1; j < SEGS; j++) begin : g_win
    logic [K-1:0] lo_sum;
    logic         lo_cout;
    logic         lo_ones;
    logic [K-1:0] hi_sum;
    logic         hi_cout;

    aca_window #(.K(K)) u_win (
      .a_win  (a_i[(j-1)*K +: 2*K]),
      .b_win  (b_i[(j-1)*K +: 2*K]),
      .lo_sum (lo_sum),
      .lo_cout(lo_cout),
      .lo_ones(lo_ones),
      .hi_sum (hi_sum),
      .hi_cout(hi_cout)
    );

    assign spec_c[j]            = lo_cout;
    assign prop[j-1]            = lo_ones;
    assign approx_sum[j*K +: K] = hi_sum;

    if (j == 1) begin : g_base
      assign approx_sum[K-1:0] = lo_sum;
    end
    if (j == SEGS - 1) begin : g_head
      assign approx_cout = hi_cout;
    end
  end

  aca_fix #(.N(N), .K(K)) u_fix (
    .approx_sum (approx_sum),
    .approx_cout(approx_cout),
    .spec_c     (spec_c),
    .prop       (prop),
    .exact_sel  (exact_i),
    .sum        (comb_sum),
    .cout       (comb_cout),
    .err        (comb_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_o  <= '0;
      cout_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      sum_o  <= comb_sum;
      cout_o <= comb_cout;
      err_o  <= comb_err;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk) $past(rst) |-> (sum_o == '0 && !cout_o && !err_o))
    else $error("outputs not cleared after reset");

  p_low_exact_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> sum_o[2*K-1:0] == ($past(a_i[2*K-1:0]) + $past(b_i[2*K-1:0])))
    else $error("low window not exact");

  p_exact_sum_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(exact_i)) |->
      {cout_o, sum_o} == ({1'b0, $past(a_i)} + {1'b0, $past(b_i)}))
    else $error("exact mode result wrong");

  p_no_overshoot_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(exact_i)) |->
      {cout_o, sum_o} <= ({1'b0, $past(a_i)} + {1'b0, $past(b_i)}))
    else $error("speculative result above true sum");

  p_flag_diff_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(exact_i)) |->
      err_o == ({cout_o, sum_o} != ({1'b0, $past(a_i)} + {1'b0, $past(b_i)})))
    else $error("flag does not track speculative error");
endmodule

// File: tb/sim_aca_top.sv
module sim_aca_top;
  localparam int BN = 8;
  localparam int BK = 2;
  localparam int BS = BN / BK;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [BN-1:0] a = '0;
  logic [BN-1:0] b = '0;
  logic          exact = 1'b0;
  logic [BN-1:0] sum;
  logic          cout;
  logic          err;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  aca_top #(.N(BN), .K(BK)) u0 (
    .clk(clk), .rst(rst), .a_i(a), .b_i(b), .exact_i(exact),
    .sum_o(sum), .cout_o(cout), .err_o(err)
  );

  function automatic logic [BN:0] spec_model(input logic [BN-1:0] x, input logic [BN-1:0] y);
    logic [BN:0]   r;
    logic [2*BK:0] base;
    logic [BK:0]   lo;
    logic [BK:0]   hi;
    r = '0;
    base = {1'b0, x[2*BK-1:0]} + {1'b0, y[2*BK-1:0]};
    r[2*BK-1:0] = base[2*BK-1:0];
    for (int j = 2; j < BS; j++) begin
      lo = {1'b0, x[(j-1)*BK +: BK]} + {1'b0, y[(j-1)*BK +: BK]};
      hi = {1'b0, x[j*BK +: BK]} + {1'b0, y[j*BK +: BK]} + {{BK{1'b0}}, lo[BK]};
      r[j*BK +: BK] = hi[BK-1:0];
      if (j == BS - 1) r[BN] = hi[BK];
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s a=%0h b=%0h mode=%0b actual=%0h expected=%0h", req, a, b, exact, act, exp);
    end
  endtask

  task automatic apply(input logic [BN-1:0] x, input logic [BN-1:0] y, input logic m);
    logic [BN:0] tru;
    logic [BN:0] spc;
    logic        flag;
    @(negedge clk);
    a = x; b = y; exact = m;
    @(posedge clk);
    #1;
    tru  = {1'b0, x} + {1'b0, y};
    spc  = spec_model(x, y);
    flag = (spc != tru);
    check(sum[2*BK-1:0] == tru[2*BK-1:0], "R3", 32'(sum[2*BK-1:0]), 32'(tru[2*BK-1:0]));
    if (m) begin
      check({cout, sum} == tru, "R8/R10", 32'({cout, sum}), 32'(tru));
      check(err == flag, "R9", 32'(err), 32'(flag));
    end else begin
      check({cout, sum} == spc, "R4/R5/R10", 32'({cout, sum}), 32'(spc));
      check(spc <= tru, "R6", 32'({cout, sum}), 32'(tru));
      check(err == flag, "R7", 32'(err), 32'(flag));
    end
  endtask

  initial begin
    // R1: reset clears outputs even with busy inputs
    a = 8'hFF; b = 8'hFF; exact = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(sum == '0 && !cout && !err, "R1", 32'({err, cout, sum}), 32'd0);
    @(negedge clk);
    rst = 1'b0;

    // R2: one-cycle latency, value follows the sampled inputs
    @(negedge clk);
    a = 8'h3C; b = 8'h11; exact = 1'b0;
    @(posedge clk);
    #1;
    check({cout, sum} == 9'h04D, "R2", 32'({cout, sum}), 32'h04D);

    // R7: carry from segment 0 into an all-ones segment 1 is lost upstream
    apply(8'h0B, 8'h05, 1'b0);
    check({cout, sum} == 9'h000 && err, "R7", 32'({err, cout, sum}), 32'h200);
    apply(8'h0B, 8'h05, 1'b1);
    check({cout, sum} == 9'h010 && err, "R9", 32'({err, cout, sum}), 32'h210);

    // R10: alternating modes on consecutive cycles
    apply(8'hFF, 8'h01, 1'b1);
    apply(8'hFF, 8'h01, 1'b0);
    apply(8'hFF, 8'h01, 1'b1);

    for (int mi = 0; mi < 2; mi++) begin
      for (int ai = 0; ai < 256; ai++) begin
        for (int bi = 0; bi < 256; bi++) begin
          apply(ai[BN-1:0], bi[BN-1:0], mi[0]);
        end
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule